// File: doc/BRIEF.md
# External Status Change Interrupt Monitor

This block watches the modem-control lines and a handful of internal status events of one serial channel and merges them into a single external/status interrupt request. Four level sources are watched for a change in either direction: clear-to-send, carrier detect, the sync line, and the combined break/abort/end-of-poll condition. Because that last source is a level, it raises a request both when the condition starts and when it ends. Two pulse sources, transmit underrun and baud-rate counter reaching zero, raise a request on each pulse. Every source has its own enable bit.

When a request is raised, a snapshot of the enabled sources is frozen so that software reads a stable value. The request stays asserted and later changes are not shown until a reset command releases the latch. Each level source keeps the reference level that was in force when the latch froze. A pulse that arrives while the latch is held is kept pending. Any difference left at release raises a fresh request on the next clock. The line synchronizers and the break/abort/end-of-poll detectors sit outside the block.

Top module: `extstat_irq_mon`

## Requirements
- R1: While reset is active and on the first cycle after it, `irq` is 0, and during reset both snapshots read all zeros.
- R2: A change in either direction on an enabled line input (`lvl_in` bit 0 clear-to-send, bit 1 carrier detect, bit 2 sync) sets `irq` on the first clock edge that samples the new level.
- R3: A one-cycle high on enabled `pls_in` bit 0 (transmit underrun) sets `irq` at that edge, and `snap_pls` bit 0 reads 1.
- R4: A one-cycle high on enabled `pls_in` bit 1 (baud-rate counter zero) sets `irq` at that edge, and `snap_pls` bit 1 reads 1.
- R5: `lvl_in` bit 3 (break/abort/end-of-poll) raises `irq` both when it rises and when it falls.
- R6: A source whose enable bit is 0 never raises `irq`, and its snapshot bit keeps its previous value.
- R7: While `irq` is high, `snap_lvl` and `snap_pls` do not change. They hold the enabled levels and pulse causes captured at the edge that raised `irq`.
- R8: `irq` stays high until a clock edge that samples `reset_cmd`=1, and is low after that edge. `reset_cmd` has no effect while `irq` is low.
- R9: If an enabled level differs at release from the level captured when the latch froze, or an enabled pulse arrived while the latch was held, `irq` is low for exactly one cycle after release and then rises again.
- R10: A line that changes and returns to its captured level while the latch is held raises no new request after release.
- R11: The first clock edge after reset loads the reference levels without raising `irq`, even when the lines are already high.
- R12: While `irq` is low, the enabled bits of `snap_lvl` follow `lvl_in` one cycle late, and the enabled bits of `snap_pls` read 0 when no pulse is due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lvl_in | input | N_LINES | Level sources: 0 clear-to-send, 1 carrier detect, 2 sync, 3 break/abort/end-of-poll |
| lvl_en | input | N_LINES | Per-line interrupt enables |
| pls_in | input | N_PULSES | Pulse sources: 0 transmit underrun, 1 baud-rate counter zero |
| pls_en | input | N_PULSES | Per-pulse interrupt enables |
| reset_cmd | input | 1 | Reset-external-status command; releases the latch |
| irq | output | 1 | Level interrupt request |
| snap_lvl | output | N_LINES | Latched line levels |
| snap_pls | output | N_PULSES | Latched pulse causes |

## Verification
The assertions assume that every input is already synchronous to `clk` and changes only between edges. They also assume that a pulse source is high for one cycle per event, because a longer pulse counts as a fresh event on every edge it is seen. The bench drives all inputs on the falling edge and keeps every pulse one cycle wide. Enables are changed only while `irq` is low, so that the snapshot rules for disabled bits are observed at the ports.

// File: rtl/extstat_pkg.sv
package extstat_pkg;
  // index meaning of the level vector
  localparam int LINE_CTS   = 0;
  localparam int LINE_DCD   = 1;
  localparam int LINE_SYNC  = 2;
  localparam int LINE_BREAK = 3;
  // index meaning of the pulse vector
  localparam int PULSE_UNDERRUN = 0;
  localparam int PULSE_ZERO     = 1;

  // a line event: armed, enabled and different from the reference level
  function automatic logic line_event(input logic cur, input logic base,
                                      input logic armed, input logic en);
    return en & armed & (cur ^ base);
  endfunction

  // a pulse event: enabled and either seen now or held pending
  function automatic logic pulse_event(input logic pls, input logic pend,
                                       input logic en);
    return en & (pls | pend);
  endfunction

  // next pending state of a pulse source
  function automatic logic pulse_pend_next(input logic pls, input logic pend,
                                           input logic en, input logic hold);
    if (!en)   return 1'b0;
    if (!hold) return 1'b0;
    return pend | pls;
  endfunction
endpackage

// File: rtl/extstat_lvl_watch.sv
module extstat_lvl_watch
  import extstat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic en_i,
  input  logic hold_i,
  output logic ev_o
);
  logic base_q;
  logic armed_q;

  // reference level follows the line only while the latch is open
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (!hold_i) begin
      base_q  <= lvl_i;
      armed_q <= 1'b1;
    end
  end

  assign ev_o = line_event(lvl_i, base_q, armed_q, en_i);
endmodule

// File: rtl/extstat_pls_catch.sv
module extstat_pls_catch
  import extstat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pls_i,
  input  logic en_i,
  input  logic hold_i,
  output logic ev_o
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pulse_pend_next(pls_i, pend_q, en_i, hold_i);
  end

  assign ev_o = pulse_event(pls_i, pend_q, en_i);
endmodule

// File: rtl/extstat_latch.sv
module extstat_latch #(
  parameter int NL = 4,
  parameter int NP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] lvl_i,
  input  logic [NL-1:0] lvl_en_i,
  input  logic [NP-1:0] pls_en_i,
  input  logic [NL-1:0] lvl_ev_i,
  input  logic [NP-1:0] pls_ev_i,
  input  logic          cmd_i,
  output logic          hold_o,
  output logic          any_ev_o,
  output logic [NL-1:0] snap_lvl_o,
  output logic [NP-1:0] snap_pls_o
);
  logic          hold_q;
  logic [NL-1:0] snap_lvl_q;
  logic [NP-1:0] snap_pls_q;

  assign any_ev_o = (|lvl_ev_i) | (|pls_ev_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= 1'b0;
    else if (hold_q) hold_q <= !cmd_i;
    else             hold_q <= any_ev_o;
  end

  // snapshot is transparent for enabled bits while open, frozen while held
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_lvl_q <= '0;
      snap_pls_q <= '0;
    end else if (!hold_q) begin
      for (int i = 0; i < NL; i++)
        if (lvl_en_i[i]) snap_lvl_q[i] <= lvl_i[i];
      for (int j = 0; j < NP; j++)
        if (pls_en_i[j]) snap_pls_q[j] <= pls_ev_i[j];
    end
  end

  assign hold_o     = hold_q;
  assign snap_lvl_o = snap_lvl_q;
  assign snap_pls_o = snap_pls_q;
endmodule

// File: rtl/extstat_irq_mon.sv
module extstat_irq_mon #(
  parameter int N_LINES  = 4,
  parameter int N_PULSES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_LINES-1:0]  lvl_in,
  input  logic [N_LINES-1:0]  lvl_en,
  input  logic [N_PULSES-1:0] pls_in,
  input  logic [N_PULSES-1:0] pls_en,
  input  logic                reset_cmd,
  output logic                irq,
  output logic [N_LINES-1:0]  snap_lvl,
  output logic [N_PULSES-1:0] snap_pls
);
  // named internal events for the checker
  logic [N_LINES-1:0]  lvl_ev;
  logic [N_PULSES-1:0] pls_ev;
  logic                hold;
  logic                any_ev;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    extstat_lvl_watch u_watch (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (lvl_in[g]),
      .en_i   (lvl_en[g]),
      .hold_i (hold),
      .ev_o   (lvl_ev[g])
    );
  end

  for (genvar g = 0; g < N_PULSES; g++) begin : g_pulse
    extstat_pls_catch u_catch (
      .clk    (clk),
      .rst_n  (rst_n),
      .pls_i  (pls_in[g]),
      .en_i   (pls_en[g]),
      .hold_i (hold),
      .ev_o   (pls_ev[g])
    );
  end

  extstat_latch #(.NL(N_LINES), .NP(N_PULSES)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_i      (lvl_in),
    .lvl_en_i   (lvl_en),
    .pls_en_i   (pls_en),
    .lvl_ev_i   (lvl_ev),
    .pls_ev_i   (pls_ev),
    .cmd_i      (reset_cmd),
    .hold_o     (hold),
    .any_ev_o   (any_ev),
    .snap_lvl_o (snap_lvl),
    .snap_pls_o (snap_pls)
  );

  assign irq = hold;
endmodule

// File: rtl/extstat_irq_mon_chk.sv
module extstat_irq_mon_chk #(
  parameter int NL = 4,
  parameter int NP = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic          reset_cmd,
  input logic          any_ev,
  input logic [NL-1:0] lvl_en,
  input logic [NP-1:0] pls_en,
  input logic [NL-1:0] snap_lvl,
  input logic [NP-1:0] snap_pls
);
  p_hold_until_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !reset_cmd) |=> irq);

  p_cmd_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && reset_cmd) |=> !irq);

  p_snap_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !reset_cmd) |=> ($stable(snap_lvl) && $stable(snap_pls)));

  p_event_raises_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && any_ev) |=> irq);

  p_quiet_stays_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !any_ev) |=> !irq);

  p_disabled_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && lvl_en == '0 && pls_en == '0) |=> (!irq && $stable(snap_lvl) && $stable(snap_pls)));
endmodule

bind extstat_irq_mon extstat_irq_mon_chk #(.NL(N_LINES), .NP(N_PULSES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq       (irq),
  .reset_cmd (reset_cmd),
  .any_ev    (any_ev),
  .lvl_en    (lvl_en),
  .pls_en    (pls_en),
  .snap_lvl  (snap_lvl),
  .snap_pls  (snap_pls)
);

// File: tb/extstat_irq_mon_bench.sv
module extstat_irq_mon_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] lvl_in = '0;
  logic [3:0] lvl_en = '0;
  logic [1:0] pls_in = '0;
  logic [1:0] pls_en = '0;
  logic       reset_cmd = 1'b0;
  logic       irq;
  logic [3:0] snap_lvl;
  logic [1:0] snap_pls;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  extstat_irq_mon u_extstat_irq_mon (
    .clk(clk), .rst_n(rst_n), .lvl_in(lvl_in), .lvl_en(lvl_en),
    .pls_in(pls_in), .pls_en(pls_en), .reset_cmd(reset_cmd),
    .irq(irq), .snap_lvl(snap_lvl), .snap_pls(snap_pls)
  );

  typedef struct packed {
    logic [3:0] lvl;
    logic [1:0] pls;
    logic [3:0] len;
    logic [1:0] pen;
    logic       cmd;
    logic       eirq;
    logic [3:0] esl;
    logic [1:0] esp;
  } vec_t;

  // one row per cycle; expected outputs after the edge that samples the row
  localparam vec_t VECS [20] = '{
    '{4'b0000, 2'b00, 4'hF, 2'b11, 1'b0, 1'b0, 4'b0000, 2'b00}, // R12 idle
    '{4'b0001, 2'b00, 4'hF, 2'b11, 1'b0, 1'b1, 4'b0001, 2'b00}, // R2 cts rise
    '{4'b0011, 2'b00, 4'hF, 2'b11, 1'b0, 1'b1, 4'b0001, 2'b00}, // R7 dcd while held
    '{4'b0011, 2'b00, 4'hF, 2'b11, 1'b1, 1'b0, 4'b0001, 2'b00}, // R8 release
    '{4'b0011, 2'b00, 4'hF, 2'b11, 1'b0, 1'b1, 4'b0011, 2'b00}, // R9 re-raise
    '{4'b0011, 2'b00, 4'hF, 2'b11, 1'b1, 1'b0, 4'b0011, 2'b00}, // R8
    '{4'b0011, 2'b00, 4'hF, 2'b11, 1'b0, 1'b0, 4'b0011, 2'b00}, // R12
    '{4'b0011, 2'b01, 4'hF, 2'b11, 1'b0, 1'b1, 4'b0011, 2'b01}, // R3 underrun
    '{4'b0011, 2'b00, 4'hF, 2'b11, 1'b1, 1'b0, 4'b0011, 2'b01}, // R8
    '{4'b0011, 2'b00, 4'hF, 2'b11, 1'b0, 1'b0, 4'b0011, 2'b00}, // R12 cause cleared
    '{4'b1011, 2'b00, 4'hF, 2'b11, 1'b0, 1'b1, 4'b1011, 2'b00}, // R5 break start
    '{4'b1011, 2'b10, 4'hF, 2'b11, 1'b0, 1'b1, 4'b1011, 2'b00}, // R9 zero while held
    '{4'b1011, 2'b00, 4'hF, 2'b11, 1'b1, 1'b0, 4'b1011, 2'b00}, // R8
    '{4'b1011, 2'b00, 4'hF, 2'b11, 1'b0, 1'b1, 4'b1011, 2'b10}, // R4 pending zero
    '{4'b1011, 2'b00, 4'hF, 2'b11, 1'b1, 1'b0, 4'b1011, 2'b10}, // R8
    '{4'b0011, 2'b00, 4'hF, 2'b11, 1'b0, 1'b1, 4'b0011, 2'b00}, // R5 break end
    '{4'b0011, 2'b00, 4'hF, 2'b11, 1'b1, 1'b0, 4'b0011, 2'b00}, // R8
    '{4'b0111, 2'b00, 4'h0, 2'b00, 1'b0, 1'b0, 4'b0011, 2'b00}, // R6 sync disabled
    '{4'b0111, 2'b11, 4'h0, 2'b00, 1'b0, 1'b0, 4'b0011, 2'b00}, // R6 pulses disabled
    '{4'b0111, 2'b00, 4'hF, 2'b11, 1'b0, 1'b0, 4'b0111, 2'b00}  // R6 no late event
  };

  task automatic check(input string req, input logic eirq,
                       input logic [3:0] esl, input logic [1:0] esp);
    tests++;
    if (irq !== eirq || snap_lvl !== esl || snap_pls !== esp) begin
      fails++;
      $display("FAIL %s: irq=%b snap_lvl=%b snap_pls=%b expected irq=%b snap_lvl=%b snap_pls=%b",
               req, irq, snap_lvl, snap_pls, eirq, esl, esp);
    end
  endtask

  task automatic step(input logic [3:0] l, input logic [1:0] p,
                      input logic [3:0] le, input logic [1:0] pe, input logic c);
    lvl_in = l; pls_in = p; lvl_en = le; pls_en = pe; reset_cmd = c;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0, 4'b0000, 2'b00);
    rst_n = 1'b1;

    for (int k = 0; k < 20; k++) begin
      step(VECS[k].lvl, VECS[k].pls, VECS[k].len, VECS[k].pen, VECS[k].cmd);
      check($sformatf("table row %0d", k), VECS[k].eirq, VECS[k].esl, VECS[k].esp);
    end

    // R2 falling edge, then R10 toggle back while held
    step(4'b0110, 2'b00, 4'hF, 2'b11, 1'b0);
    check("R2 cts fall", 1'b1, 4'b0110, 2'b00);
    step(4'b0111, 2'b00, 4'hF, 2'b11, 1'b0);
    step(4'b0110, 2'b00, 4'hF, 2'b11, 1'b0);
    check("R10 held", 1'b1, 4'b0110, 2'b00);
    step(4'b0110, 2'b00, 4'hF, 2'b11, 1'b1);
    step(4'b0110, 2'b00, 4'hF, 2'b11, 1'b0);
    check("R10 no re-raise", 1'b0, 4'b0110, 2'b00);
    step(4'b0110, 2'b00, 4'hF, 2'b11, 1'b0);
    check("R10 still quiet", 1'b0, 4'b0110, 2'b00);

    // R8 command with no request pending
    step(4'b0110, 2'b00, 4'hF, 2'b11, 1'b1);
    check("R8 idle cmd", 1'b0, 4'b0110, 2'b00);
    step(4'b0100, 2'b00, 4'hF, 2'b11, 1'b0);
    check("R2 dcd fall after idle cmd", 1'b1, 4'b0100, 2'b00);
    step(4'b0100, 2'b00, 4'hF, 2'b11, 1'b1);

    // R6 only clear-to-send enabled
    step(4'b0110, 2'b00, 4'b0001, 2'b00, 1'b0);
    check("R6 dcd disabled", 1'b0, 4'b0100, 2'b00);
    step(4'b0111, 2'b00, 4'b0001, 2'b00, 1'b0);
    check("R6 cts enabled", 1'b1, 4'b0101, 2'b00);
    step(4'b0111, 2'b00, 4'b0001, 2'b00, 1'b1);
    check("R8 release", 1'b0, 4'b0101, 2'b00);

    // R11 lines high across reset
    lvl_in = 4'hF; lvl_en = 4'hF; pls_en = 2'b11; reset_cmd = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset again", 1'b0, 4'b0000, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 first cycle", 1'b0, 4'b1111, 2'b00);
    @(negedge clk);
    check("R11 no spurious", 1'b0, 4'b1111, 2'b00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule